// File: doc/BRIEF.md
# EPROM chip erase sequencer

This block is a synchronous controller that electrically erases a byte-wide reprogrammable read-only memory. It drives the memory's address and data inputs and its active-low chip enable and output enable. It also drives a supply-select line and a flag that asks the board to put the high erase voltage on address pin 9. The supply generator and the memory array sit outside the block.

A one-cycle `start` pulse runs the whole sequence without further help. The block raises the supply to the erase level and waits for it to settle. It then fires a whole-chip erase pulse and holds the address lines after the pulse ends. Next it reads back the bytes one at a time in erase-verify mode, and each byte must read all ones. When a byte fails, the block fires another erase pulse and continues verifying from that same byte. A bounded retry count ends the attempt. Once every byte verifies, the block drops the supply to the normal level, removes the high-voltage flag and reads the whole array once more as a blank check. The result appears on `pass` or `fail` and stays there until the next start.

The FSM states are ST_IDLE, ST_RAMP, ST_PULSE, ST_HOLD, ST_VSET, ST_VCHK, ST_BRAMP, ST_BSET, ST_BCHK, ST_PASS and ST_FAIL. Their transitions are:
- IDLE, PASS or FAIL go to RAMP on `start`. This clears the retry count and the address pointer.
- RAMP goes to PULSE after SETUP_CYC cycles.
- PULSE goes to HOLD after PULSE_CYC cycles.
- HOLD goes to VSET after HOLD_CYC cycles.
- VSET goes to VCHK after OES_CYC cycles.
- VCHK handles the byte it just read:
  - On a good byte it goes back to VSET with the next address. After the last address it goes to BRAMP.
  - On a bad byte it goes to RAMP, or to FAIL when the retry limit is reached.
- BRAMP goes to BSET after SETUP_CYC cycles.
- BSET goes to BCHK after OES_CYC cycles.
- BCHK handles the byte it just read:
  - On a good byte it goes to BSET with the next address. After the last address it goes to PASS.
  - On a bad byte it goes to FAIL.

Top module: `eprom_erase_seq`

## Requirements
- R1: Out of reset, the outputs are idle: `busy`, `pass`, `fail`, `vpp_hi` (1 = 14 V erase level, 0 = 5 V) and `a9_hv` are 0, `ce_n` and `oe_n` are 1, and `mem_addr` and `mem_din` are 0.
- R2: One cycle after `start`, the block drives `vpp_hi`=1, `a9_hv`=1, `mem_addr`=0, `mem_din`=8'hFF and `ce_n`=`oe_n`=1. It holds these for SETUP_CYC cycles before any erase pulse.
- R3: The erase pulse is `ce_n` low for exactly PULSE_CYC cycles. Throughout the pulse, `oe_n`=1, `mem_addr`=0, `mem_din`=8'hFF, and the erase level and A9 flag are on.
- R4: After each pulse, `ce_n` returns high while `mem_addr` stays 0 for HOLD_CYC cycles.
- R5: Verify presents each address in ascending order with `ce_n`=1, `oe_n`=0 and the erase level and A9 flag still on. Each address is held for OES_CYC+1 cycles, and `mem_dout` is judged in the last of them. A byte passes only when it equals 8'hFF.
- R6: A verify failure starts another erase round (RAMP, PULSE, HOLD). Verification then resumes at the address that failed, not at address 0.
- R7: When the count of failed verify rounds reaches MAX_TRIES (default 20), the block stops. It then asserts `fail` with `busy` low, having issued exactly MAX_TRIES erase pulses.
- R8: When all addresses verify, the block first drops `vpp_hi` and `a9_hv` to 0 with both enables high for SETUP_CYC cycles. It then reads every address with `ce_n`=`oe_n`=0, each for OES_CYC+1 cycles. Any byte other than 8'hFF ends the run with `fail`.
- R9: When every blank-check byte equals 8'hFF, `pass` is asserted with `busy` low.
- R10: `busy` is 1 from the cycle after `start` until a result is reached. `start` during `busy` has no effect. `pass` and `fail` are never both 1, are held until the next `start`, and a `start` from either result begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an erase run (ignored while busy) |
| mem_dout | input | 8 | Byte read back from the memory |
| mem_addr | output | ADDR_W | Memory address |
| mem_din | output | 8 | Data driven to the memory inputs |
| ce_n | output | 1 | Active-low chip enable; low in erase phase is the erase pulse |
| oe_n | output | 1 | Active-low output enable |
| vpp_hi | output | 1 | Supply select: 1 = erase level, 0 = normal level |
| a9_hv | output | 1 | Request high voltage on address pin 9 |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Run ended with the array blank |
| fail | output | 1 | Run ended without a blank array |

## Verification
The assertions check several rules on every cycle:
- whenever the chip is enabled at the erase level, the address is zero, the data is all ones and output enable is high;
- outputs are never enabled at the erase level with chip enable low;
- the A9 flag is never raised at the normal supply;
- every erase pulse lasts exactly PULSE_CYC cycles;
- no run issues more than MAX_TRIES pulses;
- `pass` and `fail` never overlap.

Other behaviour only the scenarios can show:
- where verification resumes after a retry;
- that slow bytes are erased by the right number of pulses;
- that a blank-check mismatch ends the run;
- that `start` is ignored mid-run.

The bench shows these by comparing every output on every cycle against a trace built from a model memory whose bytes need chosen numbers of pulses.

// File: rtl/eprom_erase_seq_pkg.sv
package eprom_erase_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RAMP,
        ST_PULSE,
        ST_HOLD,
        ST_VSET,
        ST_VCHK,
        ST_BRAMP,
        ST_BSET,
        ST_BCHK,
        ST_PASS,
        ST_FAIL
    } seq_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/eprom_erase_seq_timer.sv
// Phase timer: restarts on every state change, reports the last cycle of a phase.
module eprom_erase_seq_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    assign expired = (cnt == limit - TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (restart)  cnt <= '0;
        else if (!expired) cnt <= cnt + TW'(1);
    end
endmodule

// File: rtl/eprom_erase_seq_walker.sv
// Address pointer shared by erase verify and blank check.
module eprom_erase_seq_walker #(
    parameter int unsigned ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr,
    output logic              last
);
    assign last = &ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ptr <= '0;
        else if (clear) ptr <= '0;
        else if (step)  ptr <= ptr + ADDR_W'(1);
    end
endmodule

// File: rtl/eprom_erase_seq_retry.sv
// Counts failed verify rounds; flags the failure that reaches the limit.
module eprom_erase_seq_retry #(
    parameter int unsigned MAX_TRIES = 20,
    localparam int unsigned CW = $clog2(MAX_TRIES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic limit_hit
);
    logic [CW-1:0] cnt;

    assign limit_hit = (cnt == CW'(MAX_TRIES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (bump)  cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/eprom_erase_seq.sv
module eprom_erase_seq
    import eprom_erase_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned SETUP_CYC = 200,
    parameter int unsigned PULSE_CYC = 10_000_000,
    parameter int unsigned HOLD_CYC  = 200,
    parameter int unsigned OES_CYC   = 200,
    parameter int unsigned MAX_TRIES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        mem_dout,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_din,
    output logic              ce_n,
    output logic              oe_n,
    output logic              vpp_hi,
    output logic              a9_hv,
    output logic              busy,
    output logic              pass,
    output logic              fail
);
    localparam int unsigned MAX_A  = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int unsigned MAX_B  = (PULSE_CYC > OES_CYC) ? PULSE_CYC : OES_CYC;
    localparam int unsigned MAXCYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned TW     = $clog2(MAXCYC + 1);

    seq_state_e        state, state_nxt;
    logic [TW-1:0]     limit;
    logic              expired, ptr_clr, ptr_step, try_clr, try_bump, limit_hit, last;
    logic [ADDR_W-1:0] ptr;
    logic              byte_ok;

    assign byte_ok = (mem_dout == ERASED_BYTE);

    eprom_erase_seq_timer #(.TW(TW)) timer_i (
        .clk(clk), .rst_n(rst_n), .restart(state_nxt != state),
        .limit(limit), .expired(expired)
    );

    eprom_erase_seq_walker #(.ADDR_W(ADDR_W)) walker_i (
        .clk(clk), .rst_n(rst_n), .clear(ptr_clr), .step(ptr_step),
        .ptr(ptr), .last(last)
    );

    eprom_erase_seq_retry #(.MAX_TRIES(MAX_TRIES)) retry_i (
        .clk(clk), .rst_n(rst_n), .clear(try_clr), .bump(try_bump),
        .limit_hit(limit_hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next state and phase length
    always_comb begin
        state_nxt = state;
        limit     = TW'(1);
        ptr_clr   = 1'b0;
        ptr_step  = 1'b0;
        try_clr   = 1'b0;
        try_bump  = 1'b0;
        unique case (state)
            ST_IDLE, ST_PASS, ST_FAIL: begin
                if (start) begin
                    state_nxt = ST_RAMP;
                    ptr_clr   = 1'b1;
                    try_clr   = 1'b1;
                end
            end
            ST_RAMP: begin
                limit = TW'(SETUP_CYC);
                if (expired) state_nxt = ST_PULSE;
            end
            ST_PULSE: begin
                limit = TW'(PULSE_CYC);
                if (expired) state_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                limit = TW'(HOLD_CYC);
                if (expired) state_nxt = ST_VSET;
            end
            ST_VSET: begin
                limit = TW'(OES_CYC);
                if (expired) state_nxt = ST_VCHK;
            end
            ST_VCHK: begin
                if (!byte_ok) begin
                    try_bump  = 1'b1;
                    state_nxt = limit_hit ? ST_FAIL : ST_RAMP;
                end else if (last) begin
                    ptr_clr   = 1'b1;
                    state_nxt = ST_BRAMP;
                end else begin
                    ptr_step  = 1'b1;
                    state_nxt = ST_VSET;
                end
            end
            ST_BRAMP: begin
                limit = TW'(SETUP_CYC);
                if (expired) state_nxt = ST_BSET;
            end
            ST_BSET: begin
                limit = TW'(OES_CYC);
                if (expired) state_nxt = ST_BCHK;
            end
            ST_BCHK: begin
                if (!byte_ok)  state_nxt = ST_FAIL;
                else if (last) state_nxt = ST_PASS;
                else begin
                    ptr_step  = 1'b1;
                    state_nxt = ST_BSET;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        mem_addr = '0;
        mem_din  = 8'h00;
        ce_n     = 1'b1;
        oe_n     = 1'b1;
        vpp_hi   = 1'b0;
        a9_hv    = 1'b0;
        busy     = 1'b1;
        pass     = 1'b0;
        fail     = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_PASS: begin busy = 1'b0; pass = 1'b1; end
            ST_FAIL: begin busy = 1'b0; fail = 1'b1; end
            ST_RAMP, ST_HOLD: begin
                vpp_hi = 1'b1; a9_hv = 1'b1; mem_din = ERASED_BYTE;
            end
            ST_PULSE: begin
                vpp_hi = 1'b1; a9_hv = 1'b1; mem_din = ERASED_BYTE; ce_n = 1'b0;
            end
            ST_VSET, ST_VCHK: begin
                vpp_hi = 1'b1; a9_hv = 1'b1; oe_n = 1'b0; mem_addr = ptr;
            end
            ST_BRAMP: mem_addr = ptr;
            ST_BSET, ST_BCHK: begin
                ce_n = 1'b0; oe_n = 1'b0; mem_addr = ptr;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/eprom_erase_seq_chk.sv
module eprom_erase_seq_chk #(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned PULSE_CYC = 10_000_000,
    parameter int unsigned MAX_TRIES = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_din,
    input logic              ce_n,
    input logic              oe_n,
    input logic              vpp_hi,
    input logic              a9_hv,
    input logic              busy,
    input logic              pass,
    input logic              fail
);
    int unsigned low_cnt;
    int unsigned pulse_cnt;
    logic        ce_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt   <= 0;
            pulse_cnt <= 0;
            ce_q      <= 1'b1;
        end else begin
            ce_q    <= ce_n;
            low_cnt <= ce_n ? 0 : low_cnt + 1;
            if (!busy)                       pulse_cnt <= 0;
            else if (ce_q && !ce_n && vpp_hi) pulse_cnt <= pulse_cnt + 1;
        end
    end

    p_pulse_inputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && vpp_hi) |-> (mem_addr == '0 && mem_din == 8'hFF && oe_n && a9_hv));

    p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ce_n) && vpp_hi) |-> (low_cnt == PULSE_CYC));

    p_verify_ce_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && !oe_n) |-> ce_n);

    p_a9_low_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_hi |-> !a9_hv);

    p_try_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pulse_cnt <= MAX_TRIES));

    p_result_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail) && !(busy && (pass || fail)));

    p_result_on_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (pass || fail));
endmodule

bind eprom_erase_seq eprom_erase_seq_chk #(
    .ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC), .MAX_TRIES(MAX_TRIES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_din(mem_din),
    .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi), .a9_hv(a9_hv),
    .busy(busy), .pass(pass), .fail(fail)
);

// File: tb/eprom_erase_seq_tb_top.sv
module eprom_erase_seq_tb_top;
    localparam int AW    = 3;
    localparam int NB    = 1 << AW;
    localparam int SETUP = 3;
    localparam int PULSE = 5;
    localparam int HOLD  = 2;
    localparam int OES   = 2;
    localparam int MAXT  = 20;

    typedef struct {
        logic [15:0] vals;   // {busy, vpp, a9, ce_n, oe_n, din, addr}
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    mem_dout;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_din;
    logic          ce_n, oe_n, vpp_hi, a9_hv, busy, pass, fail;

    int   nchk = 0, nfail = 0, cyc = 0;
    int   need [NB];
    int   bad_blank = -1;
    int   pulses = 0;
    logic clr_pulses = 1'b0;
    logic ce_prev = 1'b1;
    exp_t expq [$];

    always #2 clk = ~clk;

    eprom_erase_seq #(
        .ADDR_W(AW), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
        .HOLD_CYC(HOLD), .OES_CYC(OES), .MAX_TRIES(MAXT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_dout(mem_dout),
        .mem_addr(mem_addr), .mem_din(mem_din), .ce_n(ce_n), .oe_n(oe_n),
        .vpp_hi(vpp_hi), .a9_hv(a9_hv), .busy(busy), .pass(pass), .fail(fail)
    );

    // Memory model: a byte needs need[a] pulses to read FF; one byte may fail blank check
    always_comb begin
        mem_dout = 8'hFF;
        if (pulses < need[mem_addr]) mem_dout = 8'hF7;
        if (!vpp_hi && int'(mem_addr) == bad_blank) mem_dout = 8'hFE;
    end

    always @(negedge clk) begin
        if (clr_pulses) pulses <= 0;
        else if (ce_prev && !ce_n && vpp_hi && a9_hv) pulses <= pulses + 1;
        ce_prev <= ce_n;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            nfail = nfail + 1;
            $display("FAIL R10 watchdog: run hung, got busy=%0b exp 0", busy);
            $display("  [TB] %0d tests run, %0d failed", nchk + 1, nfail);
            $finish;
        end
    end

    task automatic push(int n, bit b, bit v, bit a9, bit ce, bit oe,
                        logic [7:0] din, int addr, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.vals = {b, v, a9, ce, oe, din, AW'(addr)};
            e.tag  = tag;
            expq.push_back(e);
        end
    endtask

    // Expected trace built from the requirements
    task automatic build(output bit ok, output int npulse);
        int p = 0, tries = 0, ptr = 0;
        bit good;
        expq.delete();
        forever begin
            push(SETUP, 1, 1, 1, 1, 1, 8'hFF, 0, (p == 0) ? "R2" : "R6");
            push(PULSE, 1, 1, 1, 0, 1, 8'hFF, 0, "R3");
            p++;
            push(HOLD, 1, 1, 1, 1, 1, 8'hFF, 0, "R4");
            good = 1'b1;
            while (ptr < NB) begin
                push(OES + 1, 1, 1, 1, 1, 0, 8'h00, ptr, (tries > 0) ? "R6" : "R5");
                if (p < need[ptr]) begin good = 1'b0; break; end
                ptr++;
            end
            if (good) break;
            tries++;
            if (tries == MAXT) begin ok = 1'b0; npulse = p; return; end
        end
        push(SETUP, 1, 0, 0, 1, 1, 8'h00, 0, "R8");
        for (int a = 0; a < NB; a++) begin
            push(OES + 1, 1, 0, 0, 0, 0, 8'h00, a, "R8");
            if (a == bad_blank) begin ok = 1'b0; npulse = p; return; end
        end
        ok = 1'b1;
        npulse = p;
    endtask

    task automatic check(bit cond, string tag, string what, int got, int expv);
        nchk++;
        if (!cond) begin
            nfail++;
            $display("FAIL %s %s: got %0h exp %0h", tag, what, got, expv);
        end
    endtask

    task automatic check_result(bit exp_ok, string tag);
        check(busy == 1'b0, "R10", "busy at result", int'(busy), 0);
        check(pass == exp_ok && fail == !exp_ok, tag, "pass/fail",
              int'({pass, fail}), int'({exp_ok, !exp_ok}));
    endtask

    task automatic run_case(string name, int inject);
        bit   exp_ok;
        int   exp_p;
        int   idx = 0;
        bit   cyc_bad = 1'b0;
        build(exp_ok, exp_p);
        $display("[TB] case %s: %0d cycles expected", name, expq.size());
        @(negedge clk);
        clr_pulses = 1'b1;
        start = 1'b1;
        @(negedge clk);
        clr_pulses = 1'b0;
        start = 1'b0;
        while (expq.size() > 0) begin
            exp_t        e;
            logic [15:0] got;
            e   = expq.pop_front();
            got = {busy, vpp_hi, a9_hv, ce_n, oe_n, mem_din, mem_addr};
            start = (idx == inject);  // R10: start mid-run must change nothing
            if (got !== e.vals || pass || fail) begin
                cyc_bad = 1'b1;
                check(1'b0, e.tag, $sformatf("cycle %0d outputs", idx), int'(got), int'(e.vals));
            end
            idx++;
            @(negedge clk);
        end
        start = 1'b0;
        check(!cyc_bad, "R5", "per-cycle trace", int'(cyc_bad), 0);
        check_result(exp_ok, exp_ok ? "R9" : "R7");
        check(pulses == exp_p, exp_ok ? "R6" : "R7", "erase pulses", pulses, exp_p);
        repeat (3) @(negedge clk);
        check_result(exp_ok, "R10");
    endtask

    initial begin
        for (int a = 0; a < NB; a++) need[a] = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({busy, pass, fail, vpp_hi, a9_hv, ce_n, oe_n} == 7'b0000011 &&
              mem_addr == '0 && mem_din == 8'h00, "R1", "reset outputs",
              int'({busy, pass, fail, vpp_hi, a9_hv, ce_n, oe_n}), 'b11);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && ce_n == 1'b1, "R1", "idle after reset", int'(busy), 0);

        // R2 R3 R4 R5 R8 R9 R10: clean array, start injected mid-run
        run_case("single_pulse", 10);

        // R6: slow bytes, resume at failing address
        need[2] = 2; need[5] = 3;
        run_case("retries", -1);

        // R7: one byte never erases within the limit
        for (int a = 0; a < NB; a++) need[a] = 1;
        need[3] = 25;
        run_case("retry_limit", -1);

        // R8: blank check mismatch at normal supply
        need[3] = 1;
        bad_blank = 6;
        run_case("blank_mismatch", -1);

        // R9 R10: restart from fail and pass
        bad_blank = -1;
        need[0] = 2;
        run_case("restart_pass", -1);

        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule